// File: doc/BRIEF.md
# Binary Time-of-Day Counter

This block keeps the time of day on a 24-hour cycle. A single clock carries one pulse per second, and every rising edge advances the time by one second. Seconds, minutes and hours are each held as a plain binary number, not BCD. Together they drive seventeen output bits: six for seconds, six for minutes and five for hours. Display decoding, time setting, alarms and calendar fields belong to other blocks.

Each field is a chain of toggle stages. The lowest bit flips on every enabled pulse. A higher bit flips only when all bits below it in the same field are 1. Each field also detects its own last value. On the next enabled pulse it returns to zero, and the next field up is enabled for that one pulse. Every flop shares the one clock, so the carries between fields are clock enables and never derived clocks.

An active-low reset is sampled on the clock edge. While it is low, every field is held at zero and no counting takes place.

Top module: `tod_counter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all three fields are zero after that edge, and they stay zero as long as `rst_n` stays low.
- R2: When seconds is below 59, each pulse raises seconds by exactly one.
- R3: When seconds is 59, the next pulse sets seconds to 0 and raises minutes by one, unless minutes is 59.
- R4: When seconds and minutes are both 59, the next pulse sets both to 0 and raises hours by one, unless hours is 23.
- R5: When the time is 23:59:59, the next pulse sets seconds, minutes and hours to 0 on the same edge.
- R6: Minutes change only on a pulse where seconds is 59. Hours change only on a pulse where seconds and minutes are both 59.
- R7: After `rst_n` goes high, the outputs after N pulses equal N modulo 86400. This value is split as hours = value/3600, minutes = (value/60) mod 60 and seconds = value mod 60.
- R8: Seconds and minutes never exceed 59, and hours never exceeds 23.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | One pulse per second; every flop is clocked on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low: holds all fields at zero |
| sec_o | output | 6 | Seconds, binary 0..59 |
| min_o | output | 6 | Minutes, binary 0..59 |
| hr_o | output | 5 | Hours, binary 0..23 |

## Verification
On every edge the assertions check the local step rules. These are the reset clear, the one-step increment of seconds, the wrap of seconds and minutes with the carry, the midnight clear, the stability of the upper fields without a carry, and the range limits. Only the bench's scenarios can show that these local steps add up to the correct time over a whole day. The bench walks through all 86400 states plus the midnight wrap and compares each one with the pulse count taken modulo 86400. It also asserts reset in the middle of a run, then checks that the outputs hold at zero and that counting starts again from zero.

// File: rtl/tod_pkg.sv
package tod_pkg;
  // Number of bits needed to hold values 0..max_val.
  function automatic int unsigned bits_for(input int unsigned max_val);
    int unsigned w;
    w = 1;
    while ((max_val >> w) != 0) w = w + 1;
    return w;
  endfunction
endpackage

// File: rtl/tod_wrap_stage.sv
// One field of the clock: a chain of toggle stages that returns to zero after LAST.
module tod_wrap_stage #(
  parameter int unsigned LAST = 59,
  parameter int unsigned W    = tod_pkg::bits_for(LAST)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  localparam logic [W-1:0] LAST_V = W'(LAST);

  logic [W-1:0] cnt_q;
  logic [W:0]   low_ones;
  logic [W-1:0] tgl;

  assign low_ones[0] = 1'b1;

  generate
    for (genvar i = 0; i < W; i++) begin : g_tgl
      assign low_ones[i+1] = low_ones[i] & cnt_q[i];
      assign tgl[i]        = low_ones[i];
    end
  endgenerate

  assign last_o = (cnt_q == LAST_V);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (en_i) begin
      if (last_o) cnt_q <= '0;
      else        cnt_q <= cnt_q ^ tgl;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tod_counter.sv
module tod_counter #(
  parameter int unsigned SEC_LAST = 59,
  parameter int unsigned MIN_LAST = 59,
  parameter int unsigned HR_LAST  = 23,
  localparam int unsigned SEC_W = tod_pkg::bits_for(SEC_LAST),
  localparam int unsigned MIN_W = tod_pkg::bits_for(MIN_LAST),
  localparam int unsigned HR_W  = tod_pkg::bits_for(HR_LAST)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [SEC_W-1:0] sec_o,
  output logic [MIN_W-1:0] min_o,
  output logic [HR_W-1:0]  hr_o
);
  logic sec_last, min_last, hr_last;
  logic min_en, hr_en;

  assign min_en = sec_last;
  assign hr_en  = sec_last & min_last;

  tod_wrap_stage #(.LAST(SEC_LAST), .W(SEC_W)) i_sec (
    .clk(clk), .rst_n(rst_n), .en_i(1'b1),  .cnt_o(sec_o), .last_o(sec_last)
  );
  tod_wrap_stage #(.LAST(MIN_LAST), .W(MIN_W)) i_min (
    .clk(clk), .rst_n(rst_n), .en_i(min_en), .cnt_o(min_o), .last_o(min_last)
  );
  tod_wrap_stage #(.LAST(HR_LAST), .W(HR_W)) i_hr (
    .clk(clk), .rst_n(rst_n), .en_i(hr_en),  .cnt_o(hr_o),  .last_o(hr_last)
  );
endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk #(
  parameter int unsigned SEC_LAST = 59,
  parameter int unsigned MIN_LAST = 59,
  parameter int unsigned HR_LAST  = 23,
  parameter int unsigned SEC_W = 6,
  parameter int unsigned MIN_W = 6,
  parameter int unsigned HR_W  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEC_W-1:0] sec_o,
  input logic [MIN_W-1:0] min_o,
  input logic [HR_W-1:0]  hr_o,
  input logic             hr_last
);
  localparam logic [SEC_W-1:0] SL = SEC_W'(SEC_LAST);
  localparam logic [MIN_W-1:0] ML = MIN_W'(MIN_LAST);
  localparam logic [HR_W-1:0]  HL = HR_W'(HR_LAST);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (sec_o == '0 && min_o == '0 && hr_o == '0));

  // R2
  sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_o != SL) |=> (sec_o == $past(sec_o) + 1'b1));

  // R3
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_o == SL && min_o != ML) |=> (sec_o == '0 && min_o == $past(min_o) + 1'b1));

  // R4
  min_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_o == SL && min_o == ML && hr_o != HL) |=>
      (min_o == '0 && hr_o == $past(hr_o) + 1'b1));

  // R5
  day_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hr_last && sec_o == SL && min_o == ML) |=> (sec_o == '0 && min_o == '0 && hr_o == '0));

  // R6
  min_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_o != SL) |=> $stable(min_o) && $stable(hr_o));

  // R6
  hr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (min_o != ML) |=> $stable(hr_o));

  // R8
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_o <= SL && min_o <= ML && hr_o <= HL));
endmodule

bind tod_counter tod_counter_chk #(
  .SEC_LAST(SEC_LAST), .MIN_LAST(MIN_LAST), .HR_LAST(HR_LAST),
  .SEC_W(SEC_W), .MIN_W(MIN_W), .HR_W(HR_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .sec_o(sec_o), .min_o(min_o), .hr_o(hr_o), .hr_last(hr_last)
);

// File: tb/test_tod_counter.sv
module test_tod_counter;
  localparam int CLK_PERIOD = 10;
  localparam int DAY = 86400;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] sec_o;
  logic [5:0] min_o;
  logic [4:0] hr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tod_counter i_tod_counter (
    .clk(clk), .rst_n(rst_n), .sec_o(sec_o), .min_o(min_o), .hr_o(hr_o)
  );

  task automatic check_time(input int n, input string tag);
    int e, hh, mm, ss;
    e  = n % DAY;
    hh = e / 3600;
    mm = (e / 60) % 60;
    ss = e % 60;
    checks++;
    if (int'(hr_o) != hh || int'(min_o) != mm || int'(sec_o) != ss) begin
      fails++;
      $display("FAIL %s pulse %0d: actual %0d:%0d:%0d expected %0d:%0d:%0d",
               tag, n, hr_o, min_o, sec_o, hh, mm, ss);
    end
  endtask

  task automatic check_range();
    checks++;
    if (sec_o > 6'd59 || min_o > 6'd59 || hr_o > 5'd23) begin
      fails++;
      $display("FAIL R8: actual %0d:%0d:%0d expected within 23:59:59", hr_o, min_o, sec_o);
    end
  endtask

  function automatic string tag_for(input int n);
    int p;
    p = (n - 1) % DAY;
    if (p == DAY - 1)       return "R5/R7";
    if (p % 3600 == 3599)   return "R4/R7";
    if (p % 60 == 59)       return "R3/R6/R7";
    return "R2/R6/R7";
  endfunction

  task automatic run_pulses(input int count);
    for (int n = 1; n <= count; n++) begin
      @(posedge clk);
      @(negedge clk);
      check_time(n, tag_for(n));
      if (n % 97 == 0) check_range();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset from time zero
    repeat (3) @(negedge clk);
    check_time(0, "R1");
    // full day plus the midnight wrap and a few seconds
    rst_n = 1'b1;
    run_pulses(DAY + 5);
    // R1: reset in the middle of a count holds zeros
    repeat (70) @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check_time(0, "R1");
    repeat (4) @(negedge clk);
    check_time(0, "R1");
    rst_n = 1'b1;
    // R7: counting restarts from zero after release
    run_pulses(3725);
    check_range();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule